// File: doc/BRIEF.md
# Two-Input Two-Output Packet Switch with Event Counter

The block moves 32-bit packets from two ingress queues to two egress queues. Each packet names its egress queue in one bit and carries a second bit that marks it for statistics. In each cycle the block decides which head packets to transfer. Every transfer dequeues the ingress head and enqueues the egress tail in the same clock edge. Each transferred packet that is marked for statistics adds one to a 16-bit counter.

Two packets can contend for the same resource in one cycle. They contend for an egress queue when both head for it. They contend for the counter when both are marked and head for different egress queues. In either case ingress A wins and ingress B waits. Apart from those two conflicts, every packet that can legally move moves. All four queues are internal, four entries deep, and have registered full and empty flags. Users push into the ingress queues and pop from the egress queues.

Top module: `pkt_switch2x2`

## Requirements
- R1: Packet bit 0 selects the egress: 0 routes to egress A (`outa_*`), 1 routes to egress B (`outb_*`). Bits 31:2 pass through unchanged.
- R2: A head packet moves only when its ingress queue is non-empty and its egress queue is not full. The move dequeues and enqueues in the same edge. A packet pushed at edge t is visible at its egress port after edge t+1 when no conflict delays it.
- R3: No queue is ever dequeued while empty or enqueued while full. A push into a full ingress queue is dropped, and a pop from an empty egress queue has no effect.
- R4: When both heads target the same non-full egress, only ingress A's packet moves that cycle, and B's packet follows it in the egress order.
- R5: When the heads target different non-full egresses and both have bit 1 (statistics mark) set, only ingress A's packet moves that cycle.
- R6: `stat_count` increases by exactly one for each moved packet with bit 1 set, is unchanged otherwise, and wraps from 65535 to 0.
- R7: Throughput is maximal. Two packets without a conflict move in the same cycle, and ingress B still moves when ingress A is blocked by a full egress.
- R8: Each queue is first-in first-out with 4 entries. Its full flag rises once it holds 4 entries.
- R9: After reset all queues are empty, no full flag is set, and `stat_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ina_push | input | 1 | Push into ingress A |
| ina_data | input | 32 | Packet for ingress A |
| ina_full | output | 1 | Ingress A full |
| inb_push | input | 1 | Push into ingress B |
| inb_data | input | 32 | Packet for ingress B |
| inb_full | output | 1 | Ingress B full |
| outa_pop | input | 1 | Pop from egress A |
| outa_data | output | 32 | Egress A head packet |
| outa_empty | output | 1 | Egress A empty |
| outb_pop | input | 1 | Pop from egress B |
| outb_data | output | 32 | Egress B head packet |
| outb_empty | output | 1 | Egress B empty |
| stat_count | output | 16 | Count of moved marked packets |

## Verification
The assertions assume nothing of the user side: they allow pushes into full ingress queues and pops from empty egress queues, because the block must ignore both. The stimulus deliberately makes such requests: it overfills a blocked ingress queue and pops an empty egress. The bench drives every input at the falling edge, so each input stays stable across the rising edge. Egress pops come from a monitor that compares each popped head against the expected order.

// File: rtl/pkt_switch2x2.sv
module pkt_switch2x2 #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ina_push,
  input  logic [W-1:0]  ina_data,
  output logic          ina_full,
  input  logic          inb_push,
  input  logic [W-1:0]  inb_data,
  output logic          inb_full,
  input  logic          outa_pop,
  output logic [W-1:0]  outa_data,
  output logic          outa_empty,
  input  logic          outb_pop,
  output logic [W-1:0]  outb_data,
  output logic          outb_empty,
  output logic [CW-1:0] stat_count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NQ = 4;

  // queue index: 0 ingress A, 1 ingress B, 2 egress A, 3 egress B
  logic [NQ-1:0] q_push, q_pop, q_full, q_empty;
  logic [W-1:0]  q_wdata [NQ];
  logic [W-1:0]  q_rdata [NQ];

  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [AW:0]   cnt, cnt_n;
    logic          full_r, empty_r;
    logic          do_push, do_pop;

    assign do_push = q_push[g] && !full_r;
    assign do_pop  = q_pop[g] && !empty_r;

    always_comb begin
      cnt_n = cnt;
      if (do_push && !do_pop) cnt_n = cnt + 1'b1;
      else if (do_pop && !do_push) cnt_n = cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rp      <= '0;
        wp      <= '0;
        cnt     <= '0;
        full_r  <= 1'b0;
        empty_r <= 1'b1;
      end else begin
        if (do_push) begin
          mem[wp] <= q_wdata[g];
          wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
        end
        if (do_pop) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
        cnt     <= cnt_n;
        full_r  <= (cnt_n == (AW+1)'(DEPTH));
        empty_r <= (cnt_n == '0);
      end
    end

    assign q_full[g]  = full_r;
    assign q_empty[g] = empty_r;
    assign q_rdata[g] = mem[rp];

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_r && empty_r));
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (AW+1)'(DEPTH));
  end

  // head decode
  logic dest_a, dest_b, mark_a, mark_b;
  logic room_a, room_b, ok_a, ok_b, clash, mv_a, mv_b;

  assign dest_a = q_rdata[0][0];
  assign dest_b = q_rdata[1][0];
  assign mark_a = q_rdata[0][1];
  assign mark_b = q_rdata[1][1];

  assign room_a = dest_a ? !q_full[3] : !q_full[2];
  assign room_b = dest_b ? !q_full[3] : !q_full[2];
  assign ok_a   = !q_empty[0] && room_a;
  assign ok_b   = !q_empty[1] && room_b;
  assign clash  = (dest_a == dest_b) || (mark_a && mark_b);
  assign mv_a   = ok_a;
  assign mv_b   = ok_b && !(mv_a && clash);

  assign q_push[0]  = ina_push;
  assign q_wdata[0] = ina_data;
  assign q_pop[0]   = mv_a;
  assign q_push[1]  = inb_push;
  assign q_wdata[1] = inb_data;
  assign q_pop[1]   = mv_b;

  assign q_push[2]  = (mv_a && !dest_a) || (mv_b && !dest_b);
  assign q_wdata[2] = (mv_a && !dest_a) ? q_rdata[0] : q_rdata[1];
  assign q_pop[2]   = outa_pop;
  assign q_push[3]  = (mv_a && dest_a) || (mv_b && dest_b);
  assign q_wdata[3] = (mv_a && dest_a) ? q_rdata[0] : q_rdata[1];
  assign q_pop[3]   = outb_pop;

  assign ina_full   = q_full[0];
  assign inb_full   = q_full[1];
  assign outa_data  = q_rdata[2];
  assign outa_empty = q_empty[2];
  assign outb_data  = q_rdata[3];
  assign outb_empty = q_empty[3];

  logic bump;
  assign bump = (mv_a && mark_a) || (mv_b && mark_b);

  always_ff @(posedge clk) begin
    if (!rst_n) stat_count <= '0;
    else if (bump) stat_count <= stat_count + 1'b1;
  end

  a_r1_route_a: assert property (@(posedge clk) disable iff (!rst_n)
    q_push[2] |-> !q_wdata[2][0]);
  a_r1_route_b: assert property (@(posedge clk) disable iff (!rst_n)
    q_push[3] |-> q_wdata[3][0]);
  a_r2_paired_move: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop[0] || q_pop[1]) |-> (q_push[2] || q_push[3]));
  a_r3_no_underflow_a: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop[0] |-> !q_empty[0]);
  a_r3_no_underflow_b: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop[1] |-> !q_empty[1]);
  a_r3_no_overflow_a: assert property (@(posedge clk) disable iff (!rst_n)
    q_push[2] |-> !q_full[2]);
  a_r3_no_overflow_b: assert property (@(posedge clk) disable iff (!rst_n)
    q_push[3] |-> !q_full[3]);
  a_r4_one_per_egress: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_pop[0] && q_pop[1] && dest_a == dest_b));
  a_r5_one_mark: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_pop[0] && q_pop[1] && mark_a && mark_b));
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    bump |=> stat_count == $past(stat_count) + 1'b1);
  a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(stat_count));
  a_r7_b_not_starved: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty[0] && !q_empty[1] && room_b) |-> q_pop[1]);
  a_r7_a_never_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_empty[0] && room_a) |-> q_pop[0]);
endmodule

// File: tb/pkt_switch2x2_tb.sv
module pkt_switch2x2_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ina_push = 0, inb_push = 0, outa_pop, outb_pop;
  logic [31:0] ina_data = '0, inb_data = '0, outa_data, outb_data;
  logic ina_full, inb_full, outa_empty, outb_empty;
  logic [15:0] stat_count;

  always #2.5 clk = ~clk;

  pkt_switch2x2 u_dut (
    .clk(clk), .rst_n(rst_n),
    .ina_push(ina_push), .ina_data(ina_data), .ina_full(ina_full),
    .inb_push(inb_push), .inb_data(inb_data), .inb_full(inb_full),
    .outa_pop(outa_pop), .outa_data(outa_data), .outa_empty(outa_empty),
    .outb_pop(outb_pop), .outb_data(outb_data), .outb_empty(outb_empty),
    .stat_count(stat_count)
  );

  int tests = 0, fails = 0;
  logic [31:0] exp_a[$];
  logic [31:0] exp_b[$];
  logic [15:0] exp_cnt = '0;
  logic auto_a = 0, auto_b = 0, poke_a = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] pk(input bit dst, input bit mark, input int tag);
    return {tag[29:0], mark, dst};
  endfunction

  // monitor: pops egress heads and compares with the expected order
  always @(negedge clk) begin
    outa_pop = poke_a || (auto_a && !outa_empty);
    outb_pop = auto_b && !outb_empty;
    if (auto_a && !outa_empty) begin
      if (exp_a.size() == 0) check(0, "R3 egress A extra item", outa_data, 0);
      else begin
        logic [31:0] e;
        e = exp_a.pop_front();
        check(outa_data == e, "R1 R8 egress A order", outa_data, e);
      end
    end
    if (auto_b && !outb_empty) begin
      if (exp_b.size() == 0) check(0, "R3 egress B extra item", outb_data, 0);
      else begin
        logic [31:0] e;
        e = exp_b.pop_front();
        check(outb_data == e, "R1 R8 egress B order", outb_data, e);
      end
    end
  end

  task automatic drive(input bit ea, input logic [31:0] da, input bit eb, input logic [31:0] db);
    @(negedge clk);
    ina_push = ea; ina_data = da;
    inb_push = eb; inb_data = db;
    @(negedge clk);
    ina_push = 0; inb_push = 0;
  endtask

  task automatic drain();
    auto_a = 1; auto_b = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (exp_a.size() == 0 && exp_b.size() == 0 && outa_empty && outb_empty) break;
    end
    @(negedge clk);
    check(exp_a.size() == 0 && exp_b.size() == 0, "R2 all expected delivered",
          exp_a.size() + exp_b.size(), 0);
    auto_a = 0; auto_b = 0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] p, q;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(outa_empty && outb_empty && !ina_full && !inb_full, "R9 reset flags",
          {outa_empty, outb_empty, ina_full, inb_full}, 4'b1100);
    check(stat_count == 0, "R9 reset count", stat_count, 0);

    // R2 latency and R1 routing to egress A
    p = pk(0, 0, 11);
    @(negedge clk); ina_push = 1; ina_data = p;
    @(negedge clk); ina_push = 0;
    check(outa_empty, "R2 not visible after one edge", outa_empty, 1);
    @(negedge clk);
    check(!outa_empty && outa_data == p, "R2 visible after second edge", outa_data, p);
    exp_a.push_back(p);
    drain();

    // R1 routing to egress B
    p = pk(1, 0, 12);
    exp_b.push_back(p);
    drive(0, 0, 1, p);
    @(negedge clk);
    check(outa_empty && !outb_empty, "R1 bit0=1 to egress B", {outa_empty, outb_empty}, 2'b10);
    drain();

    // R4 same egress: A first, B next
    p = pk(0, 0, 21); q = pk(0, 0, 22);
    exp_a.push_back(p); exp_a.push_back(q);
    drive(1, p, 1, q);
    drain();

    // R5 counter clash
    p = pk(0, 1, 31); q = pk(1, 1, 32);
    exp_a.push_back(p); exp_b.push_back(q);
    exp_cnt += 2;
    @(negedge clk); ina_push = 1; ina_data = p; inb_push = 1; inb_data = q;
    @(negedge clk); ina_push = 0; inb_push = 0;
    @(negedge clk);
    check(!outa_empty && outb_empty, "R5 only A moves first", {outa_empty, outb_empty}, 2'b01);
    @(negedge clk);
    check(!outb_empty, "R5 B moves next cycle", outb_empty, 0);
    check(stat_count == exp_cnt, "R6 two marked moves", stat_count, exp_cnt);
    drain();

    // R7 no conflict: both in the same cycle
    p = pk(0, 0, 41); q = pk(1, 1, 42);
    exp_a.push_back(p); exp_b.push_back(q);
    exp_cnt += 1;
    @(negedge clk); ina_push = 1; ina_data = p; inb_push = 1; inb_data = q;
    @(negedge clk); ina_push = 0; inb_push = 0;
    @(negedge clk);
    check(!outa_empty && !outb_empty, "R7 parallel moves", {outa_empty, outb_empty}, 2'b00);
    check(stat_count == exp_cnt, "R6 one marked move", stat_count, exp_cnt);
    drain();

    // R7/R8/R3: fill egress A, block ingress A, B still moves
    for (int i = 0; i < 4; i++) begin
      p = pk(0, 0, 50 + i);
      exp_a.push_back(p);
      @(negedge clk); ina_push = 1; ina_data = p;
    end
    @(negedge clk); ina_push = 0;
    repeat (2) @(negedge clk);
    p = pk(0, 0, 60); q = pk(1, 0, 61);
    exp_a.push_back(p); exp_b.push_back(q);
    drive(1, p, 1, q);
    @(negedge clk);
    check(!outb_empty && outb_data == q, "R7 B moves past blocked A", outb_data, q);
    for (int i = 0; i < 4; i++) begin
      p = pk(0, 0, 70 + i);
      if (i < 3) exp_a.push_back(p);
      @(negedge clk); ina_push = 1; ina_data = p;
    end
    @(negedge clk); ina_push = 0;
    check(ina_full, "R8 ingress full at 4 entries", ina_full, 1);
    drain();

    // R3 pop of an empty egress is ignored
    @(negedge clk); poke_a = 1;
    @(negedge clk); poke_a = 0;
    p = pk(0, 0, 80);
    exp_a.push_back(p);
    drive(1, p, 0, 0);
    @(negedge clk);
    check(!outa_empty && outa_data == p, "R3 empty pop ignored", outa_data, p);
    drain();

    // R6 wrap: stream marked packets through egress A
    auto_a = 1;
    for (int i = 0; i < 65537; i++) begin
      p = pk(0, 1, i);
      exp_a.push_back(p);
      exp_cnt += 1;
      @(negedge clk); ina_push = 1; ina_data = p;
    end
    @(negedge clk); ina_push = 0;
    drain();
    check(stat_count == exp_cnt, "R6 counter wraps", stat_count, exp_cnt);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule